// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns one indexed-addressing postbyte into a 16-bit effective address. After a `start` request it pulls the postbyte, and then any extension bytes the form needs, through a byte handshake. It takes the current X, Y, SP and PC base values and the A and B accumulators from input ports. D is formed as A in the high byte and B in the low byte. The result comes back on `ea` during a one-cycle `done` pulse.

Five families of forms share the postbyte:
- a short signed constant offset;
- auto pre/post increment or decrement, which also writes the updated base back;
- an 8-bit or 16-bit constant offset taken from the extension bytes;
- an accumulator offset;
- two indirect forms that read the final address from memory through a 16-bit read handshake.

A restricted-mode input rejects the extension-offset forms and the 16-bit indirect form. A rejected form returns a zero address and raises a flag. An extra-cycle count is reported beside each result so that the surrounding sequencer can account for timing.

Top module: `idx_addr_gen`

## Requirements
- R1: After synchronous reset, `done`, `byte_ready`, `mem_req`, `wb_en` and `illegal_form` are all low, and `ea` is zero.
- R2: When postbyte bit 5 is 0, bits 7:6 pick the base (0 = X, 1 = Y, 2 = SP, 3 = PC). Bits 4:0 are sign-extended as a two's-complement value and added to the base. No extension byte is taken and `extra_cyc` is 0.
- R3: When bit 5 is 1 and bits 7:6 are not 11, the form is auto-modify. If bit 3 is set, bits 3:0 are sign-extended to give a step of -8..-1. Otherwise the step is bits 3:0 plus one, giving 1..8. `wb_en` is high with `done`, `wb_sel` carries bits 7:6 and `wb_value` is base plus step.
- R4: In the auto-modify form, bit 4 equal to 0 makes `ea` the updated base (pre-modify). Bit 4 equal to 1 makes `ea` the original base (post-modify).
- R5: When bits 7:6 are 11, bit 2 is 0 and bits 2:0 are not 011, bits 4:3 pick the base with the same coding as R2.
  - If bit 1 is 1, two extension bytes are taken, high byte first, and added as a 16-bit offset.
  - If bit 1 is 0, one byte is taken as the low byte of the offset. The high byte of the offset is FF when bit 0 is 1 and 00 when bit 0 is 0.
  - In both cases `extra_cyc` is 1.
- R6: When bits 7:6 are 11 and bits 2:0 are 011, bits 4:3 pick the base. Two extension bytes are taken, high byte first, and their sum with the base is read through the memory port. The word read becomes `ea`, and `extra_cyc` is 1.
- R7: When bits 7:6 are 11 and bit 2 is 1, bits 1:0 choose the offset added to the base named by bits 4:3: 00 adds A, 01 adds B, 10 adds D. No byte beyond the postbyte is taken and `extra_cyc` is 0.
- R8: When bits 7:6 are 11, bit 2 is 1 and bits 1:0 are 11, base plus D is read through the memory port. The word read becomes `ea`, and `extra_cyc` is 1. Restricted mode does not affect this form.
- R9: With `restricted` high when the postbyte is taken, the R5 and R6 forms take no extension byte and make no memory read. They finish with `ea` = 0, `illegal_form` = 1, `wb_en` = 0 and `extra_cyc` = 0.
- R10: The base and accumulator values are sampled in the cycle the postbyte is taken. Later changes on those inputs do not affect the result.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `start` has no effect while an operation is in progress.
- R12: `done` is high for exactly one cycle, in the cycle after the last byte or memory handshake. `ea`, `wb_*`, `illegal_form` and `extra_cyc` are valid while `done` is high.
- R13: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding a new postbyte (taken when idle) |
| restricted | input | 1 | Reject the extension-offset and 16-bit indirect forms |
| byte_valid | input | 1 | Fetched byte is present on `byte_data` |
| byte_ready | output | 1 | Block accepts a fetched byte this cycle |
| byte_data | input | 8 | Postbyte or extension byte |
| reg_x | input | 16 | X base value |
| reg_y | input | 16 | Y base value |
| reg_sp | input | 16 | Stack pointer base value |
| reg_pc | input | 16 | Program counter base value |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 16 | Indirect read address |
| mem_ack | input | 1 | Read completes; `mem_rdata` valid |
| mem_rdata | input | 16 | Word returned by the read |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base write-back strobe for auto-modify |
| wb_sel | output | 2 | Base to write back (0 X, 1 Y, 2 SP, 3 PC) |
| wb_value | output | 16 | Updated base value |
| illegal_form | output | 1 | Form rejected under restricted mode |
| extra_cyc | output | 2 | Extra cycles charged by the form |

## Verification
`done` is due exactly one cycle after the final handshake of an operation. That handshake is the postbyte for the short, auto-modify, accumulator and rejected forms, the last extension byte for the constant-offset forms, and the memory acknowledge for the indirect forms. The bench records the cycle of every handshake it completes and demands `done` in the very next cycle. It then demands that `done` is low in the cycle after that. All result ports are sampled only in the `done` cycle, on the falling edge. The indirect forms get 0 to 2 cycles of acknowledge delay, so the address hold and the one-cycle latency are both exercised.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CYC_W  = 2;
    localparam int SHORT_W = 5;
    localparam int STEP_W  = 4;

    typedef logic [ADDR_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        FM_K5,
        FM_AUTO,
        FM_K8,
        FM_K16,
        FM_IND16,
        FM_ACC_A,
        FM_ACC_B,
        FM_ACC_D,
        FM_ACC_DIND
    } form_e;

    typedef enum logic [1:0] {
        BS_X  = 2'd0,
        BS_Y  = 2'd1,
        BS_SP = 2'd2,
        BS_PC = 2'd3
    } base_e;

    typedef struct packed {
        form_e            form;
        base_e            base;
        word_t            short_off;
        logic             post_mod;
        logic             k8_neg;
        logic             guarded;
        logic [CYC_W-1:0] extra;
    } pb_info_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POST,
        ST_EXT_HI,
        ST_EXT_LO,
        ST_MEM,
        ST_FIN
    } st_e;

    function automatic word_t sext_short(input logic [SHORT_W-1:0] f);
        return {{(ADDR_W-SHORT_W){f[SHORT_W-1]}}, f};
    endfunction

    function automatic word_t auto_step(input logic [STEP_W-1:0] f);
        if (f[STEP_W-1])
            return {{(ADDR_W-STEP_W){1'b1}}, f};
        return {{(ADDR_W-STEP_W){1'b0}}, f} + word_t'(1);
    endfunction

endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_pkg::*;
(
    input  byte_t    pb,
    output pb_info_t info
);
    always_comb begin
        info           = '0;
        info.form      = FM_K5;
        info.base      = base_e'(pb[7:6]);
        info.short_off = sext_short(pb[4:0]);
        info.post_mod  = pb[4];
        info.k8_neg    = pb[0];
        info.guarded   = 1'b0;
        info.extra     = '0;
        if (!pb[5]) begin
            info.form = FM_K5;
        end else if (pb[7:6] != 2'b11) begin
            info.form      = FM_AUTO;
            info.short_off = auto_step(pb[3:0]);
        end else begin
            info.base = base_e'(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                info.form    = FM_IND16;
                info.guarded = 1'b1;
                info.extra   = CYC_W'(1);
            end else if (!pb[2]) begin
                info.form    = pb[1] ? FM_K16 : FM_K8;
                info.guarded = 1'b1;
                info.extra   = CYC_W'(1);
            end else begin
                case (pb[1:0])
                    2'b00:   info.form = FM_ACC_A;
                    2'b01:   info.form = FM_ACC_B;
                    2'b10:   info.form = FM_ACC_D;
                    default: begin
                        info.form  = FM_ACC_DIND;
                        info.extra = CYC_W'(1);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/idx_base_sel.sv
module idx_base_sel
    import idx_pkg::*;
#(
    parameter int NUM_BASE = 4
) (
    input  word_t                         bases [NUM_BASE],
    input  logic [$clog2(NUM_BASE)-1:0]   sel,
    output word_t                         base_out
);
    always_comb begin
        base_out = '0;
        for (int i = 0; i < NUM_BASE; i++) begin
            if (sel == i[$clog2(NUM_BASE)-1:0])
                base_out = bases[i];
        end
    end
endmodule

// File: rtl/idx_seq.sv
module idx_seq
    import idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             restricted,
    input  logic             byte_valid,
    input  byte_t            byte_data,
    input  pb_info_t         info,
    input  word_t            base_now,
    input  byte_t            acc_a,
    input  byte_t            acc_b,
    input  logic             mem_ack,
    input  word_t            mem_rdata,
    output logic             byte_ready,
    output logic             mem_req,
    output word_t            mem_addr,
    output logic             done,
    output word_t            ea,
    output logic             wb_en,
    output logic [1:0]       wb_sel,
    output word_t            wb_value,
    output logic             illegal_form,
    output logic [CYC_W-1:0] extra_cyc
);
    st_e              st;
    form_e            form_q;
    logic             k8neg_q;
    word_t            base_q;
    byte_t            offhi_q;
    word_t            ea_q;
    word_t            maddr_q;
    word_t            wbval_q;
    logic [1:0]       sel_q;
    logic             wbflag_q;
    logic             ill_q;
    logic [CYC_W-1:0] extra_q;

    word_t acc_d;
    word_t ext_off;
    word_t ext_sum;

    always_comb begin
        acc_d   = {acc_a, acc_b};
        ext_off = (form_q == FM_K8) ? {{BYTE_W{k8neg_q}}, byte_data}
                                    : {offhi_q, byte_data};
        ext_sum = base_q + ext_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            form_q   <= FM_K5;
            k8neg_q  <= 1'b0;
            base_q   <= '0;
            offhi_q  <= '0;
            ea_q     <= '0;
            maddr_q  <= '0;
            wbval_q  <= '0;
            sel_q    <= '0;
            wbflag_q <= 1'b0;
            ill_q    <= 1'b0;
            extra_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start)
                        st <= ST_POST;
                end
                ST_POST: begin
                    if (byte_valid) begin
                        form_q   <= info.form;
                        k8neg_q  <= info.k8_neg;
                        base_q   <= base_now;
                        sel_q    <= info.base;
                        wbflag_q <= 1'b0;
                        ill_q    <= 1'b0;
                        extra_q  <= info.extra;
                        wbval_q  <= base_now + info.short_off;
                        case (info.form)
                            FM_K5: begin
                                ea_q <= base_now + info.short_off;
                                st   <= ST_FIN;
                            end
                            FM_AUTO: begin
                                wbflag_q <= 1'b1;
                                ea_q     <= info.post_mod ? base_now
                                                          : base_now + info.short_off;
                                st       <= ST_FIN;
                            end
                            FM_ACC_A: begin
                                ea_q <= base_now + {{BYTE_W{1'b0}}, acc_a};
                                st   <= ST_FIN;
                            end
                            FM_ACC_B: begin
                                ea_q <= base_now + {{BYTE_W{1'b0}}, acc_b};
                                st   <= ST_FIN;
                            end
                            FM_ACC_D: begin
                                ea_q <= base_now + acc_d;
                                st   <= ST_FIN;
                            end
                            FM_ACC_DIND: begin
                                maddr_q <= base_now + acc_d;
                                st      <= ST_MEM;
                            end
                            default: begin
                                if (restricted && info.guarded) begin
                                    ea_q    <= '0;
                                    ill_q   <= 1'b1;
                                    extra_q <= '0;
                                    st      <= ST_FIN;
                                end else begin
                                    st <= (info.form == FM_K8) ? ST_EXT_LO : ST_EXT_HI;
                                end
                            end
                        endcase
                    end
                end
                ST_EXT_HI: begin
                    if (byte_valid) begin
                        offhi_q <= byte_data;
                        st      <= ST_EXT_LO;
                    end
                end
                ST_EXT_LO: begin
                    if (byte_valid) begin
                        if (form_q == FM_IND16) begin
                            maddr_q <= ext_sum;
                            st      <= ST_MEM;
                        end else begin
                            ea_q <= ext_sum;
                            st   <= ST_FIN;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        ea_q <= mem_rdata;
                        st   <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_ready   = (st == ST_POST) || (st == ST_EXT_HI) || (st == ST_EXT_LO);
        mem_req      = (st == ST_MEM);
        mem_addr     = maddr_q;
        done         = (st == ST_FIN);
        ea           = ea_q;
        wb_en        = done && wbflag_q;
        wb_sel       = sel_q;
        wb_value     = wbval_q;
        illegal_form = done && ill_q;
        extra_cyc    = extra_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                    // R12
    AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past((byte_valid && byte_ready) || (mem_req && mem_ack))); // R12
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_form |-> (ea == '0));                                       // R9
    AST_REJECT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        illegal_form |-> !wb_en);                                           // R9
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));          // R11
    AST_REJECT_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
        illegal_form |-> (extra_cyc == '0));                                // R9

endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
    import idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             restricted,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    input  logic [15:0]      reg_x,
    input  logic [15:0]      reg_y,
    input  logic [15:0]      reg_sp,
    input  logic [15:0]      reg_pc,
    input  logic [7:0]       acc_a,
    input  logic [7:0]       acc_b,
    output logic             mem_req,
    output logic [15:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [15:0]      mem_rdata,
    output logic             done,
    output logic [15:0]      ea,
    output logic             wb_en,
    output logic [1:0]       wb_sel,
    output logic [15:0]      wb_value,
    output logic             illegal_form,
    output logic [1:0]       extra_cyc
);
    localparam int NUM_BASE = 4;

    pb_info_t info;
    word_t    bases [NUM_BASE];
    word_t    base_now;

    always_comb begin
        bases[BS_X]  = reg_x;
        bases[BS_Y]  = reg_y;
        bases[BS_SP] = reg_sp;
        bases[BS_PC] = reg_pc;
    end

    idx_decode u_decode (
        .pb   (byte_data),
        .info (info)
    );

    idx_base_sel #(.NUM_BASE(NUM_BASE)) u_base_sel (
        .bases    (bases),
        .sel      (info.base),
        .base_out (base_now)
    );

    idx_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .restricted   (restricted),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .info         (info),
        .base_now     (base_now),
        .acc_a        (acc_a),
        .acc_b        (acc_b),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .byte_ready   (byte_ready),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .done         (done),
        .ea           (ea),
        .wb_en        (wb_en),
        .wb_sel       (wb_sel),
        .wb_value     (wb_value),
        .illegal_form (illegal_form),
        .extra_cyc    (extra_cyc)
    );
endmodule

// File: tb/idx_addr_gen_bench.sv
module idx_addr_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, restricted, byte_valid, byte_ready;
    logic [7:0]  byte_data, acc_a, acc_b;
    logic [15:0] reg_x, reg_y, reg_sp, reg_pc;
    logic        mem_req, mem_ack, done, wb_en, illegal_form;
    logic [15:0] mem_addr, mem_rdata, ea, wb_value;
    logic [1:0]  wb_sel, extra_cyc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_addr_gen u_idx_addr_gen (
        .clk(clk), .rst(rst), .start(start), .restricted(restricted),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .acc_a(acc_a), .acc_b(acc_b),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value),
        .illegal_form(illegal_form), .extra_cyc(extra_cyc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result from the requirement text
    logic [15:0] e_ea, e_wbval, e_maddr;
    logic        e_wb, e_ill, e_mem;
    logic [1:0]  e_sel, e_extra;
    int          e_nb;
    string       e_tag;

    task automatic model(input logic [7:0] pb, input bit rs, input logic [7:0] e1,
                         input logic [7:0] e2, input logic [15:0] mw);
        logic [15:0] bx [4];
        logic [15:0] base, step, d;
        bx[0] = reg_x; bx[1] = reg_y; bx[2] = reg_sp; bx[3] = reg_pc;
        d = {acc_a, acc_b};
        e_wb = 0; e_ill = 0; e_mem = 0; e_maddr = 0; e_sel = 0; e_wbval = 0;
        e_extra = 0; e_nb = 1;
        if (!pb[5]) begin                                          // R2
            e_tag = "R2";
            e_ea = bx[pb[7:6]] + {{11{pb[4]}}, pb[4:0]};
        end else if (pb[7:6] != 2'b11) begin                       // R3 R4
            e_tag = "R4";
            base = bx[pb[7:6]];
            step = pb[3] ? {12'hFFF, pb[3:0]} : ({12'h000, pb[3:0]} + 16'd1);
            e_wb = 1; e_sel = pb[7:6]; e_wbval = base + step;
            e_ea = pb[4] ? base : base + step;
        end else begin
            base = bx[pb[4:3]];
            if (pb[2:0] == 3'b011 || !pb[2]) begin
                if (rs) begin                                       // R9
                    e_tag = "R9"; e_ea = 0; e_ill = 1;
                end else if (pb[2:0] == 3'b011) begin               // R6
                    e_tag = "R6"; e_nb = 3; e_mem = 1; e_maddr = base + {e1, e2};
                    e_ea = mw; e_extra = 1;
                end else if (pb[1]) begin                           // R5
                    e_tag = "R5"; e_nb = 3; e_ea = base + {e1, e2}; e_extra = 1;
                end else begin
                    e_tag = "R5"; e_nb = 2; e_ea = base + {pb[0] ? 8'hFF : 8'h00, e1};
                    e_extra = 1;
                end
            end else begin
                case (pb[1:0])
                    2'b00: begin e_tag = "R7"; e_ea = base + {8'h00, acc_a}; end
                    2'b01: begin e_tag = "R7"; e_ea = base + {8'h00, acc_b}; end
                    2'b10: begin e_tag = "R7"; e_ea = base + d; end
                    default: begin
                        e_tag = "R8"; e_mem = 1; e_maddr = base + d; e_ea = mw; e_extra = 1;
                    end
                endcase
            end
        end
    endtask

    task automatic run_op(input logic [7:0] pb, input bit rs, input logic [7:0] e1,
                          input logic [7:0] e2, input logic [15:0] mw, input int mdly,
                          input string extra_tag);
        logic [7:0]  bytes [3];
        int          nb = 0, waited = 0, hs_last = -10, done_at = -1;
        bit          got_done = 0, mem_seen = 0, pb_taken = 0, scrambled = 0;
        logic [15:0] maddr_obs = 0;
        logic [15:0] o_ea, o_wbval;
        logic        o_wb, o_ill;
        logic [1:0]  o_sel, o_extra;
        bytes[0] = pb; bytes[1] = e1; bytes[2] = e2;
        model(pb, rs, e1, e2, mw);
        @(negedge clk);
        start = 1; restricted = rs;
        @(negedge clk);
        start = 0;
        for (int c = 0; c < 40; c++) begin
            byte_valid = 0; mem_ack = 0; start = 0;
            if (pb_taken && !scrambled) begin                        // R10
                reg_x = ~reg_x; reg_y = reg_y ^ 16'h5A5A; reg_sp = reg_sp + 16'h0101;
                reg_pc = ~reg_pc; acc_a = ~acc_a; acc_b = acc_b ^ 8'h3C;
                scrambled = 1;
            end
            if (done) begin
                got_done = 1; done_at = c;
                o_ea = ea; o_wb = wb_en; o_sel = wb_sel; o_wbval = wb_value;
                o_ill = illegal_form; o_extra = extra_cyc;
                break;
            end
            if (byte_ready) begin
                byte_valid = 1;
                byte_data  = (nb < 3) ? bytes[nb] : 8'h00;
                nb++; hs_last = c;
                if (nb == 1) pb_taken = 1;
            end
            if (mem_req) begin
                if (mem_seen && mem_addr !== maddr_obs)
                    chk("R11 addr hold", {16'h0, mem_addr}, {16'h0, maddr_obs});
                mem_seen = 1; maddr_obs = mem_addr;
                if (waited >= mdly) begin
                    mem_ack = 1; mem_rdata = mw; hs_last = c;
                end else begin
                    waited++; start = 1;                             // R11 start ignored
                end
            end
            @(negedge clk);
        end
        byte_valid = 0; mem_ack = 0; start = 0;
        chk({"R12 done seen ", e_tag}, {31'h0, got_done}, 32'h1);
        if (got_done) begin
            chk({"R12 latency ", e_tag}, done_at, hs_last + 1);
            chk({e_tag, " ea/R10", extra_tag}, {16'h0, o_ea}, {16'h0, e_ea});
            chk({e_tag, " bytes taken"}, nb, e_nb);
            chk({e_tag, " mem read"}, {31'h0, mem_seen}, {31'h0, e_mem});
            if (e_mem) chk({e_tag, " mem addr"}, {16'h0, maddr_obs}, {16'h0, e_maddr});
            chk("R3 wb_en", {31'h0, o_wb}, {31'h0, e_wb});
            if (e_wb) begin
                chk("R3 wb_sel", {30'h0, o_sel}, {30'h0, e_sel});
                chk({"R3 wb_value", extra_tag}, {16'h0, o_wbval}, {16'h0, e_wbval});
            end
            chk("R9 illegal_form", {31'h0, o_ill}, {31'h0, e_ill});
            chk({e_tag, " extra_cyc"}, {30'h0, o_extra}, {30'h0, e_extra});
            @(negedge clk);
            chk("R12 single pulse", {31'h0, done}, 32'h0);
        end
    endtask

    task automatic set_bases(input int s);
        case (s)
            0: begin reg_x = 16'h1234; reg_y = 16'h8000; reg_sp = 16'h0FF0;
                     reg_pc = 16'hC000; acc_a = 8'h7F; acc_b = 8'h81; end
            1: begin reg_x = 16'hFFFE; reg_y = 16'hFFF9; reg_sp = 16'hFF80;   // R13
                     reg_pc = 16'hFFFF; acc_a = 8'hFF; acc_b = 8'hF0; end
            default: begin reg_x = 16'h0000; reg_y = 16'h0003; reg_sp = 16'h0007;
                     reg_pc = 16'h4001; acc_a = 8'h00; acc_b = 8'h80; end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; start = 0; restricted = 0; byte_valid = 0; byte_data = 0;
        mem_ack = 0; mem_rdata = 0;
        set_bases(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 byte_ready", {31'h0, byte_ready}, 32'h0);
        chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
        chk("R1 wb_en", {31'h0, wb_en}, 32'h0);
        chk("R1 illegal_form", {31'h0, illegal_form}, 32'h0);
        chk("R1 ea", {16'h0, ea}, 32'h0);
        for (int s = 0; s < 3; s++) begin
            for (int rs = 0; rs < 2; rs++) begin
                for (int p = 0; p < 256; p++) begin
                    logic [7:0] pb;
                    pb = 8'(p);
                    set_bases(s);
                    run_op(pb, rs[0], pb ^ 8'h5A, pb + 8'h33, {pb, ~pb}, p % 3,
                           (s == 1) ? "/R13" : "");
                end
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule